// File: doc/BRIEF.md
# I2C Ten-Bit Slave Address Matcher

This block sits above a bit-level I2C receiver. It watches byte-level bus events (start, repeated start, stop, and a received byte) and decides whether the local slave, which has a programmable 10-bit address, is being addressed. It also decides in which direction. For every byte it receives, it returns an acknowledge decision. It raises an interrupt strobe whose tag says whether the byte carried address information or payload data. It also keeps two level flags: one says the slave is currently selected, the other says it has been selected as a transmitter.

A write selection takes two bytes. The first is a header made of the fixed pattern 11110, the two top own-address bits and a direction bit of 0. The second holds the low eight address bits. Once the block has been selected this way, it remembers that fact across a repeated start. After the repeated start, a single header byte with the direction bit set to 1 is enough to switch it to transmitter mode.

Received bytes arrive on a valid-qualified stream (`rx_valid`/`rx_data`). There is no ready signal: the block accepts a byte in every cycle, so it never applies back-pressure, and the upstream receiver never has to hold a byte. Every response appears on the registered outputs exactly one clock after the byte or event that caused it.

Top module: `i2c10_addr_match`

## Requirements
- R1: After the active-low synchronous reset, every output is 0. A byte received before any start is answered with `ack_valid`=1, `ack`=0 and no interrupt.
- R2: After a start, a byte whose bits [7:1] equal {11110, own_addr[9], own_addr[8]} and whose bit 0 (the direction bit) is 0 is acknowledged. It raises `irq` with `irq_is_addr`=1 one clock after `rx_valid`.
- R3: After an accepted write header, a byte equal to own_addr[7:0] is acknowledged with an address-tagged interrupt, and `addressed` rises on the same cycle.
- R4: After an accepted write header, a byte that differs from own_addr[7:0] is not acknowledged and raises no interrupt. Every later byte is also not acknowledged until the next start or repeated start. A not-acknowledged byte never raises an interrupt.
- R5: After a start, a header byte whose bits [7:1] do not match is not acknowledged and raises no interrupt, and the following bytes are not acknowledged.
- R6: While selected as a receiver, every byte is acknowledged and raises an interrupt with `irq_is_addr`=0.
- R7: After a repeated start, if the slave was selected before, a matching header with direction bit 1 is acknowledged with an address-tagged interrupt, and both `addressed` and `tx_mode` become 1.
- R8: If the slave was not selected since the last start, a matching header with direction bit 1 is not acknowledged.
- R9: `addressed` stays set across a repeated start. It drops only when the first byte after the repeated start is not accepted.
- R10: A stop clears `addressed`, `tx_mode` and the remembered selection one clock later. A later repeated start followed by a read header is then not acknowledged.
- R11: In transmitter mode each byte strobe raises `irq` with `irq_is_addr`=0 and produces no `ack_valid`.
- R12: When events or a byte coincide, the priority is stop, then start, then repeated start, then the byte. A byte that coincides with any event is dropped and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Start condition strobe |
| ev_rstart | input | 1 | Repeated start strobe |
| ev_stop | input | 1 | Stop condition strobe |
| rx_valid | input | 1 | Received byte strobe, always accepted |
| rx_data | input | 8 | Received byte |
| own_addr | input | 10 | Own 10-bit slave address |
| ack_valid | output | 1 | An acknowledge decision is presented |
| ack | output | 1 | 1 = acknowledge, 0 = withhold |
| irq | output | 1 | Interrupt strobe for the byte |
| irq_is_addr | output | 1 | Interrupt byte was address, not data |
| addressed | output | 1 | Slave currently selected |
| tx_mode | output | 1 | Slave selected as transmitter |

## Verification
A wrong internal state shows up at the ports on the very next byte. For example, a sequencer stuck in the reject state, or a remembered-selection bit that survives a stop, shows up as a wrong acknowledge value or a wrong interrupt tag one clock after `rx_valid`. A missed clear is different: it appears on the level flags one clock after the stop, even before any byte arrives. For that reason the bench checks the response after every single byte, and checks the flags after every event rather than only at the end of a transfer.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_LOW,
    ST_RECV,
    ST_XMIT,
    ST_SKIP
  } mstate_t;

  typedef struct packed {
    logic ack_valid;
    logic ack;
    logic irq;
    logic irq_addr;
  } resp_t;
endpackage

// File: rtl/i2c10_hdr_cmp.sv
module i2c10_hdr_cmp #(
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 10,
  parameter int PREFIX_W = 5,
  parameter logic [PREFIX_W-1:0] PREFIX = 5'b11110
) (
  input  logic [BYTE_W-1:0]        rx_byte,
  input  logic [ADDR_W-BYTE_W-1:0] own_hi,
  output logic                     hdr_hit,
  output logic                     rw_bit
);
  localparam int HI_W = ADDR_W - BYTE_W;
  localparam int CMP_W = PREFIX_W + HI_W;

  logic [CMP_W-1:0] want;
  assign want    = {PREFIX, own_hi};
  assign hdr_hit = (rx_byte[BYTE_W-1:1] == want);
  assign rw_bit  = rx_byte[0];

  initial begin
    AST_HDR_WIDTH: assert (CMP_W == BYTE_W - 1)
      else $error("header layout does not fill the byte"); // R2
  end
endmodule

// File: rtl/i2c10_low_cmp.sv
module i2c10_low_cmp #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] own_lo,
  output logic              low_hit
);
  logic [BYTE_W-1:0] same;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    assign same[i] = ~(rx_byte[i] ^ own_lo[i]);
  end

  assign low_hit = &same;
endmodule

// File: rtl/i2c10_seq.sv
module i2c10_seq
  import i2c10_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ev_stop,
  input  logic  ev_start,
  input  logic  ev_rstart,
  input  logic  byte_go,
  input  logic  hdr_hit,
  input  logic  rw_bit,
  input  logic  low_hit,
  output resp_t resp,
  output logic  sel,
  output logic  sel_tx
);
  mstate_t st;
  logic    seen;

  function automatic resp_t mk(input logic v, input logic a, input logic i, input logic t);
    resp_t r;
    r.ack_valid = v;
    r.ack       = a;
    r.irq       = i;
    r.irq_addr  = t;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      sel    <= 1'b0;
      sel_tx <= 1'b0;
      seen   <= 1'b0;
      resp   <= '0;
    end else begin
      resp <= '0;
      if (ev_stop) begin
        st     <= ST_IDLE;
        sel    <= 1'b0;
        sel_tx <= 1'b0;
        seen   <= 1'b0;
      end else if (ev_start) begin
        st     <= ST_HDR;
        sel    <= 1'b0;
        sel_tx <= 1'b0;
        seen   <= 1'b0;
      end else if (ev_rstart) begin
        st <= ST_HDR;
      end else if (byte_go) begin
        unique case (st)
          ST_HDR: begin
            if (hdr_hit && !rw_bit) begin
              resp   <= mk(1'b1, 1'b1, 1'b1, 1'b1);
              st     <= ST_LOW;
              sel    <= 1'b0;
              sel_tx <= 1'b0;
              seen   <= 1'b0;
            end else if (hdr_hit && rw_bit && seen) begin
              resp   <= mk(1'b1, 1'b1, 1'b1, 1'b1);
              st     <= ST_XMIT;
              sel    <= 1'b1;
              sel_tx <= 1'b1;
            end else begin
              resp   <= mk(1'b1, 1'b0, 1'b0, 1'b0);
              st     <= ST_SKIP;
              sel    <= 1'b0;
              sel_tx <= 1'b0;
              seen   <= 1'b0;
            end
          end
          ST_LOW: begin
            if (low_hit) begin
              resp <= mk(1'b1, 1'b1, 1'b1, 1'b1);
              st   <= ST_RECV;
              sel  <= 1'b1;
              seen <= 1'b1;
            end else begin
              resp <= mk(1'b1, 1'b0, 1'b0, 1'b0);
              st   <= ST_SKIP;
            end
          end
          ST_RECV: resp <= mk(1'b1, 1'b1, 1'b1, 1'b0);
          ST_XMIT: resp <= mk(1'b0, 1'b0, 1'b1, 1'b0);
          default: resp <= mk(1'b1, 1'b0, 1'b0, 1'b0);
        endcase
      end
    end
  end

  AST_TX_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_tx |-> sel); // R7
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!sel && !sel_tx && st == ST_IDLE)); // R10
  AST_NACK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (resp.ack_valid && !resp.ack) |-> !resp.irq); // R4
  AST_RESP_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    resp.irq |-> $past(byte_go)); // R12
  AST_TX_ENTRY_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_tx) |-> (resp.irq && resp.irq_addr && resp.ack)); // R7
  AST_RECV_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RECV && byte_go && !ev_stop && !ev_start && !ev_rstart)
      |=> (resp.ack && resp.irq && !resp.irq_addr)); // R6
endmodule

// File: rtl/i2c10_addr_match.sv
module i2c10_addr_match
  import i2c10_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_rstart,
  input  logic              ev_stop,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              ack_valid,
  output logic              ack,
  output logic              irq,
  output logic              irq_is_addr,
  output logic              addressed,
  output logic              tx_mode
);
  localparam int HI_W = ADDR_W - BYTE_W;

  logic  hdr_hit, rw_bit, low_hit;
  resp_t resp;

  i2c10_hdr_cmp #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_hdr (
    .rx_byte (rx_data),
    .own_hi  (own_addr[ADDR_W-1 -: HI_W]),
    .hdr_hit (hdr_hit),
    .rw_bit  (rw_bit)
  );

  i2c10_low_cmp #(.BYTE_W(BYTE_W)) u_low (
    .rx_byte (rx_data),
    .own_lo  (own_addr[BYTE_W-1:0]),
    .low_hit (low_hit)
  );

  i2c10_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_stop   (ev_stop),
    .ev_start  (ev_start),
    .ev_rstart (ev_rstart),
    .byte_go   (rx_valid),
    .hdr_hit   (hdr_hit),
    .rw_bit    (rw_bit),
    .low_hit   (low_hit),
    .resp      (resp),
    .sel       (addressed),
    .sel_tx    (tx_mode)
  );

  assign ack_valid   = resp.ack_valid;
  assign ack         = resp.ack;
  assign irq         = resp.irq;
  assign irq_is_addr = resp.irq_addr;

  AST_ACK_ONE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> ($past(rx_valid) && !$past(ev_stop) && !$past(ev_start) && !$past(ev_rstart))); // R12
  AST_TAG_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_is_addr |-> irq); // R2
endmodule

// File: tb/i2c10_addr_match_test.sv
module i2c10_addr_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_start = 1'b0, ev_rstart = 1'b0, ev_stop = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [9:0] own_addr = 10'h2A5;
  logic       ack_valid, ack, irq, irq_is_addr, addressed, tx_mode;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  i2c10_addr_match uut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_rstart(ev_rstart),
    .ev_stop(ev_stop), .rx_valid(rx_valid), .rx_data(rx_data),
    .own_addr(own_addr), .ack_valid(ack_valid), .ack(ack), .irq(irq),
    .irq_is_addr(irq_is_addr), .addressed(addressed), .tx_mode(tx_mode)
  );

  function automatic logic [3:0] rsp();
    return {ack_valid, ack, irq, irq_is_addr};
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic ev(input int which);
    @(negedge clk);
    ev_stop   = (which == 0);
    ev_start  = (which == 1);
    ev_rstart = (which == 2);
    @(negedge clk);
    ev_stop = 1'b0; ev_start = 1'b0; ev_rstart = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [7:0] hdr(input logic [9:0] a, input logic rw);
    return {5'b11110, a[9:8], rw};
  endfunction

  initial begin
    #1_200_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [9:0] owns [2];
    owns[0] = 10'h2A5;
    owns[1] = 10'h15A;
    for (int k = 0; k < 2; k++) begin
      own_addr = owns[k];
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset outputs", {rsp(), addressed, tx_mode}, 4'b0000);
      send(8'hF0);
      chk("R1 byte before start", rsp(), 4'b1000);

      // R2 R5 R8: sweep every first byte after a start
      for (int h = 0; h < 256; h++) begin
        logic acc;
        ev(0);
        ev(1);
        send(h[7:0]);
        acc = (h[7:1] == {5'b11110, own_addr[9:8]}) && (h[0] == 1'b0);
        chk(acc ? "R2 header accept" : "R5 R8 header reject", rsp(), acc ? 4'b1111 : 4'b1000);
        if (!acc) begin
          send(own_addr[7:0]);
          chk("R5 later byte rejected", rsp(), 4'b1000);
        end
      end

      // R3 R4 R6: sweep every second byte
      for (int l = 0; l < 256; l++) begin
        logic hit;
        ev(0);
        ev(1);
        send(hdr(own_addr, 1'b0));
        send(l[7:0]);
        hit = (l[7:0] == own_addr[7:0]);
        chk(hit ? "R3 low byte accept" : "R4 low byte reject", rsp(), hit ? 4'b1111 : 4'b1000);
        chk("R3 addressed flag", {3'b000, addressed}, {3'b000, hit});
        send(8'h5C);
        chk(hit ? "R6 data acked" : "R4 later byte rejected", rsp(), hit ? 4'b1110 : 4'b1000);
      end

      // R6 R9 R7 R11 R10 sequence
      ev(0);
      ev(1);
      send(hdr(own_addr, 1'b0));
      send(own_addr[7:0]);
      for (int d = 0; d < 3; d++) begin
        send(8'(d * 37 + 1));
        chk("R6 receiver data", rsp(), 4'b1110);
      end
      ev(2);
      chk("R9 still addressed after rstart", {2'b00, addressed, tx_mode}, 4'b0010);
      send(hdr(own_addr, 1'b1));
      chk("R7 read header accepted", rsp(), 4'b1111);
      chk("R7 flags", {2'b00, addressed, tx_mode}, 4'b0011);
      send(8'hA7);
      chk("R11 transmit byte", rsp(), 4'b0010);
      ev(0);
      chk("R10 stop clears flags", {2'b00, addressed, tx_mode}, 4'b0000);
      ev(2);
      send(hdr(own_addr, 1'b1));
      chk("R10 memory cleared by stop", rsp(), 4'b1000);

      // R9: different header after rstart drops selection
      ev(1);
      send(hdr(own_addr, 1'b0));
      send(own_addr[7:0]);
      ev(2);
      send(hdr(own_addr ^ 10'h100, 1'b1));
      chk("R9 other header rejected", rsp(), 4'b1000);
      chk("R9 selection dropped", {2'b00, addressed, tx_mode}, 4'b0000);
      ev(2);
      send(hdr(own_addr, 1'b1));
      chk("R9 memory gone", rsp(), 4'b1000);

      // R8: read header straight after start
      ev(1);
      send(hdr(own_addr, 1'b1));
      chk("R8 read without prior select", rsp(), 4'b1000);

      // R12: start and byte together
      ev(0);
      @(negedge clk);
      ev_start = 1'b1; rx_valid = 1'b1; rx_data = hdr(own_addr, 1'b0);
      @(negedge clk);
      ev_start = 1'b0; rx_valid = 1'b0;
      chk("R12 byte with start dropped", rsp(), 4'b0000);
      send(hdr(own_addr, 1'b0));
      chk("R12 start took effect", rsp(), 4'b1111);
      send(own_addr[7:0]);
      // R12: stop and byte together while receiving
      @(negedge clk);
      ev_stop = 1'b1; rx_valid = 1'b1; rx_data = 8'h11;
      @(negedge clk);
      ev_stop = 1'b0; rx_valid = 1'b0;
      chk("R12 byte with stop dropped", {rsp()[3:1], addressed}, 4'b0000);
      // R12: stop beats start
      @(negedge clk);
      ev_stop = 1'b1; ev_start = 1'b1;
      @(negedge clk);
      ev_stop = 1'b0; ev_start = 1'b0;
      send(hdr(own_addr, 1'b0));
      chk("R12 stop over start", rsp(), 4'b1000);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule